// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block takes thirteen level-sensitive interrupt request lines and chooses one of them to present to a small 8-bit processor core. The thirteen lines are two external pins, two timers, one serial-bus unit and eight port-pin lines. A four-register write/read interface holds a per-source enable bit, a per-source priority bit (0 = low, 1 = high) and one master enable. The block drives a registered request, a 4-bit vector index that is unique per source, and the level of the granted source.

The core reports the start of a service routine on `irq_ack` and its end on `irq_ret`. A two-entry in-service stack records the levels of the routines in progress. While a low-level routine runs, only high-level sources may interrupt it. While a high-level routine runs, no source is presented. Within one level, a fixed order decides ties.

Top module: `nirq_top`

## Requirements
- R1: Synchronous reset clears every enable bit, every priority bit, the master enable and the in-service stack. After reset all four registers read 0 and `irq_req` is 0.
- R2: Address 0 is the low-bank enable register:
  - bit 7 is the master enable;
  - bit 5 enables the serial source;
  - bits 3, 2, 1 and 0 enable timer 1, external 1, timer 0 and external 0;
  - bits 6 and 4 always read 0.
- R3: Address 1 holds the port-pin enables, port 9 down to port 2 in bits 7 down to 0. Address 2 holds the low-bank priorities, at the same positions as address 0. Its bits 7, 6 and 4 read 0. Address 3 holds the port-pin priorities, at the same positions as address 1.
- R4: While the master enable is 0, `irq_req` stays 0 whatever the sources and the other enables are.
- R5: A source whose enable bit is 0 is never presented.
- R6: When any eligible high-level source is requesting, a high-level source is presented ahead of every low-level source.
- R7: Vector indices and the tie order within a level are the same. From first to last, with their indices:

  | Index | Source |
  |-------|--------|
  | 0 | external 0 |
  | 1 | timer 0 |
  | 2 | external 1 |
  | 3 | timer 1 |
  | 4 | serial |
  | 5 to 12 | port 2 to port 9 |

  The lowest index wins.
- R8: Nesting:
  - with a low-level routine in service, only high-level sources are presented;
  - with a high-level routine in service, nothing is presented;
  - with nothing in service, both levels are presented.
- R9: `irq_ack` while `irq_req` is 1 pushes `irq_lvl` onto the in-service stack. `irq_ack` while `irq_req` is 0 is ignored. `irq_ret` pops the most recent level. `irq_ret` on an empty stack, or in a cycle where an acknowledge is taken, is ignored.
- R10: `irq_req`, `irq_vec` and `irq_lvl` are registers. After a clock edge they reflect the source inputs, the register write and the acknowledge/return sampled at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | 13 | Source request levels, bit = vector index |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` (combinational) |
| irq_ack | input | 1 | Core has entered the presented routine |
| irq_ret | input | 1 | Core has left the current routine |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 4 | Vector index of the presented source |
| irq_lvl | output | 1 | Level of the presented source |

## Verification
The bench drives every source at once and then retires them one by one. This exposes a tie order that is reversed or skips a source, which would show up as a wrong `irq_vec`.

It starts a low-level routine and then raises a high-level source, and checks that the preemption is presented. It then acknowledges the high one and checks that everything stays silent until a return. A stack that popped the wrong level would re-open low sources too early.

Acknowledges with no request, returns on an empty stack and a simultaneous acknowledge/return each leave visible traces on `irq_req` if mishandled. Writes of all ones check that the unused register bits read 0. A long random phase compares every output on every clock.

// File: rtl/nirq_pkg.sv
package nirq_pkg;

    localparam int NSRC     = 13;
    localparam int VEC_W    = $clog2(NSRC);
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int NBANK_LO = 5;
    localparam int NBANK_HI = NSRC - NBANK_LO;
    localparam int MASTER_BIT = 7;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_EN_LO  = 2'd0,
        RA_EN_HI  = 2'd1,
        RA_PRI_LO = 2'd2,
        RA_PRI_HI = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic             req;
        logic             lvl;
        logic [VEC_W-1:0] vec;
    } grant_t;

    // lowest set bit wins
    function automatic pick_t first_set(input src_vec_t v);
        pick_t p;
        p = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.idx   = VEC_W'(i);
            end
        end
        return p;
    endfunction

    // low bank sits at bits 0..3 and 5 of its register
    function automatic logic [DATA_W-1:0] pack_lo(input logic [NBANK_LO-1:0] b);
        logic [DATA_W-1:0] r;
        r      = '0;
        r[3:0] = b[3:0];
        r[5]   = b[4];
        return r;
    endfunction

    function automatic logic [NBANK_LO-1:0] unpack_lo(input logic [DATA_W-1:0] d);
        return {d[5], d[3:0]};
    endfunction

endpackage

// File: rtl/nirq_regs.sv
module nirq_regs
    import nirq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output src_vec_t              en_d,
    output src_vec_t              pri_d,
    output logic                  master_d,
    output src_vec_t              en_q,
    output logic                  master_q
);

    src_vec_t pri_q;

    always_comb begin
        en_d     = en_q;
        pri_d    = pri_q;
        master_d = master_q;
        if (wr) begin
            unique case (reg_addr_e'(addr))
                RA_EN_LO: begin
                    en_d[NBANK_LO-1:0] = unpack_lo(wdata);
                    master_d           = wdata[MASTER_BIT];
                end
                RA_EN_HI:  en_d[NSRC-1:NBANK_LO]  = wdata[NBANK_HI-1:0];
                RA_PRI_LO: pri_d[NBANK_LO-1:0]    = unpack_lo(wdata);
                RA_PRI_HI: pri_d[NSRC-1:NBANK_LO] = wdata[NBANK_HI-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            pri_q    <= '0;
            master_q <= 1'b0;
        end else begin
            en_q     <= en_d;
            pri_q    <= pri_d;
            master_q <= master_d;
        end
    end

    always_comb begin
        unique case (reg_addr_e'(addr))
            RA_EN_LO: begin
                rdata             = pack_lo(en_q[NBANK_LO-1:0]);
                rdata[MASTER_BIT] = master_q;
            end
            RA_EN_HI:  rdata = DATA_W'(en_q[NSRC-1:NBANK_LO]);
            RA_PRI_LO: rdata = pack_lo(pri_q[NBANK_LO-1:0]);
            RA_PRI_HI: rdata = DATA_W'(pri_q[NSRC-1:NBANK_LO]);
            default:   rdata = '0;
        endcase
    end

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_e'(addr) == RA_EN_LO) |-> (rdata[6] == 1'b0 && rdata[4] == 1'b0)); // R2

endmodule

// File: rtl/nirq_svc.sv
module nirq_svc
    import nirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic push_lvl,
    input  logic pop,
    output logic hi_q,
    output logic lo_q,
    output logic hi_d,
    output logic lo_d
);

    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        if (push) begin
            if (push_lvl) hi_d = 1'b1;
            else          lo_d = 1'b1;
        end else if (pop) begin
            if (hi_q)     hi_d = 1'b0;
            else          lo_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    AST_NO_PUSH_OVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        push |-> !hi_q); // R8
    AST_NO_LOW_OVER_LOW: assert property (@(posedge clk) disable iff (rst)
        (push && !push_lvl) |-> !lo_q); // R8

endmodule

// File: rtl/nirq_arb.sv
module nirq_arb
    import nirq_pkg::*;
(
    input  src_vec_t src,
    input  src_vec_t en,
    input  src_vec_t pri,
    input  logic     master,
    input  logic     svc_hi,
    input  logic     svc_lo,
    output grant_t   grant
);

    src_vec_t elig;
    src_vec_t mask_hi;
    src_vec_t mask_lo;
    pick_t    pk_hi;
    pick_t    pk_lo;

    for (genvar i = 0; i < NSRC; i++) begin : g_mask
        assign elig[i]    = src[i] & en[i] & master;
        assign mask_hi[i] = elig[i] & pri[i] & ~svc_hi;
        assign mask_lo[i] = elig[i] & ~pri[i] & ~svc_hi & ~svc_lo;
    end

    always_comb begin
        pk_hi = first_set(mask_hi);
        pk_lo = first_set(mask_lo);
        grant = '0;
        if (pk_hi.valid) begin
            grant.req = 1'b1;
            grant.lvl = 1'b1;
            grant.vec = pk_hi.idx;
        end else if (pk_lo.valid) begin
            grant.req = 1'b1;
            grant.lvl = 1'b0;
            grant.vec = pk_lo.idx;
        end
    end

endmodule

// File: rtl/nirq_top.sv
module nirq_top
    import nirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_req,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              irq_ack,
    input  logic              irq_ret,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic              irq_lvl
);

    src_vec_t en_d, pri_d, en_q;
    logic     master_d, master_q;
    logic     hi_q, lo_q, hi_d, lo_d;
    logic     ack_take, ret_take;
    grant_t   grant, grant_q;

    assign ack_take = irq_ack & grant_q.req;
    assign ret_take = irq_ret & ~ack_take;

    nirq_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .en_d     (en_d),
        .pri_d    (pri_d),
        .master_d (master_d),
        .en_q     (en_q),
        .master_q (master_q)
    );

    nirq_svc u_svc (
        .clk      (clk),
        .rst      (rst),
        .push     (ack_take),
        .push_lvl (grant_q.lvl),
        .pop      (ret_take),
        .hi_q     (hi_q),
        .lo_q     (lo_q),
        .hi_d     (hi_d),
        .lo_d     (lo_d)
    );

    nirq_arb u_arb (
        .src    (src_req),
        .en     (en_d),
        .pri    (pri_d),
        .master (master_d),
        .svc_hi (hi_d),
        .svc_lo (lo_d),
        .grant  (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) grant_q <= '0;
        else     grant_q <= grant;
    end

    assign irq_req = grant_q.req;
    assign irq_vec = grant_q.vec;
    assign irq_lvl = grant_q.lvl;

    AST_MASTER_GATES: assert property (@(posedge clk) disable iff (rst)
        !master_q |-> !irq_req); // R4
    AST_SOURCE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> en_q[irq_vec]); // R5
    AST_HIGH_BLOCKS_ALL: assert property (@(posedge clk) disable iff (rst)
        hi_q |-> !irq_req); // R8
    AST_LOW_ONLY_PREEMPTED: assert property (@(posedge clk) disable iff (rst)
        (lo_q && irq_req) |-> irq_lvl); // R8
    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (int'(irq_vec) < NSRC)); // R7

endmodule

// File: tb/nirq_top_tb_top.sv
module nirq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] src_req = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        irq_req;
    logic [3:0]  irq_vec;
    logic        irq_lvl;

    always #2 clk = ~clk;

    nirq_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_req   (src_req),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .irq_ack   (irq_ack),
        .irq_ret   (irq_ret),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .irq_lvl   (irq_lvl)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    finished = 0;

    // reference model state
    bit m_en[13];
    bit m_pri[13];
    bit m_master;
    bit m_stk[$];
    bit m_req;
    int m_vec;
    bit m_lvl;

    function automatic logic [7:0] m_read(input int a);
        logic [7:0] r = '0;
        case (a)
            0: begin
                for (int k = 0; k < 4; k++) r[k] = m_en[k];
                r[5] = m_en[4];
                r[7] = m_master;
            end
            1: for (int k = 0; k < 8; k++) r[k] = m_en[5 + k];
            2: begin
                for (int k = 0; k < 4; k++) r[k] = m_pri[k];
                r[5] = m_pri[4];
            end
            default: for (int k = 0; k < 8; k++) r[k] = m_pri[5 + k];
        endcase
        return r;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic [12:0] s, input bit a, input bit r,
                              input bit w, input int ad, input logic [7:0] d);
        bit ack_ok = a && m_req;
        bit found = 0;
        if (ack_ok) m_stk.push_back(m_lvl);
        else if (r && m_stk.size() > 0) void'(m_stk.pop_back());
        if (w) begin
            case (ad)
                0: begin
                    for (int k = 0; k < 4; k++) m_en[k] = d[k];
                    m_en[4] = d[5];
                    m_master = d[7];
                end
                1: for (int k = 0; k < 8; k++) m_en[5 + k] = d[k];
                2: begin
                    for (int k = 0; k < 4; k++) m_pri[k] = d[k];
                    m_pri[4] = d[5];
                end
                default: for (int k = 0; k < 8; k++) m_pri[5 + k] = d[k];
            endcase
        end
        m_req = 0; m_vec = 0; m_lvl = 0;
        // high level first, unless a high routine is running
        if (!(m_stk.size() > 0 && m_stk[m_stk.size() - 1])) begin
            for (int k = 0; k < 13 && !found; k++)
                if (s[k] && m_en[k] && m_master && m_pri[k]) begin
                    found = 1; m_req = 1; m_vec = k; m_lvl = 1;
                end
            if (m_stk.size() == 0)
                for (int k = 0; k < 13 && !found; k++)
                    if (s[k] && m_en[k] && m_master && !m_pri[k]) begin
                        found = 1; m_req = 1; m_vec = k; m_lvl = 0;
                    end
        end
    endtask

    task automatic step(input logic [12:0] s, input bit a, input bit r,
                        input bit w, input int ad, input logic [7:0] d);
        src_req = s; irq_ack = a; irq_ret = r;
        cfg_wr = w; cfg_addr = 2'(ad); cfg_wdata = d;
        #1;
        chk("rdata", int'(cfg_rdata), int'(m_read(ad)));
        model_step(s, a, r, w, ad, d);
        @(posedge clk); #1;
        chk("req", int'(irq_req), int'(m_req));
        if (m_req) begin
            chk("vec", int'(irq_vec), m_vec);
            chk("lvl", int'(irq_lvl), int'(m_lvl));
        end
    endtask

    task automatic wr(input int ad, input logic [7:0] d);
        step(src_req, 0, 0, 1, ad, d);
    endtask

    task automatic idle(input logic [12:0] s, input int n);
        for (int i = 0; i < n; i++) step(s, 0, 0, 0, i % 4, 8'h00);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hang expected completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 13; k++) begin m_en[k] = 0; m_pri[k] = 0; end
        m_master = 0; m_req = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state, all registers read 0, no request
        tag = "R1";
        chk("req_after_reset", int'(irq_req), 0);
        idle(13'h1FFF, 4);

        // R2: low enable register, reserved bits read 0
        tag = "R2";
        wr(0, 8'hFF); wr(0, 8'h00); idle('0, 1);
        wr(0, 8'h5A); idle('0, 1); wr(0, 8'h00);
        // R3: other three registers
        tag = "R3";
        wr(1, 8'hA5); wr(2, 8'hFF); wr(3, 8'h3C); idle('0, 4);
        wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h00);

        // R4: master off blocks everything
        tag = "R4";
        wr(0, 8'h2F); wr(1, 8'hFF);
        idle(13'h1FFF, 3);
        wr(2, 8'h2F); idle(13'h1FFF, 2); wr(2, 8'h00);
        // R10: one cycle from write to request
        tag = "R10";
        wr(0, 8'hAF);
        idle(13'h1FFF, 1);

        // R7: walk the tie order, lowest pending index wins
        tag = "R7";
        for (int i = 0; i < 13; i++) begin
            step(13'h1FFF << i, 0, 0, 0, 0, 0);
            step(13'h1FFF << i, 1, 0, 0, 0, 0);
            step(13'h1FFF << i, 0, 1, 0, 0, 0);
        end

        // R6: a high source beats all lower indices
        tag = "R6";
        wr(3, 8'h80);
        idle(13'h1FFF, 2);
        wr(3, 8'h00); wr(2, 8'h20);
        idle(13'h001F, 2);

        // R8: nesting
        tag = "R8";
        wr(2, 8'h00); wr(3, 8'h81);
        step(13'h0001, 0, 0, 0, 0, 0);
        step(13'h0001, 1, 0, 0, 0, 0);          // low in service
        step(13'h0003, 0, 0, 0, 0, 0);          // another low: blocked
        step(13'h1003, 0, 0, 0, 0, 0);          // high preempts
        step(13'h1023, 1, 0, 0, 0, 0);          // high in service
        idle(13'h1FFF, 3);                       // all blocked
        step(13'h1FFF, 0, 1, 0, 0, 0);          // pop high, low still active
        idle(13'h0003, 2);
        step(13'h0003, 0, 1, 0, 0, 0);          // pop low
        idle(13'h0003, 2);

        // R9: ack without request, ret on empty, ack with ret
        tag = "R9";
        idle('0, 1);
        step('0, 1, 0, 0, 0, 0);
        step(13'h0001, 0, 1, 0, 0, 0);
        step(13'h0001, 1, 1, 0, 0, 0);
        idle(13'h0001, 2);
        step(13'h0001, 0, 1, 0, 0, 0);
        idle(13'h0001, 1);

        // R5: partial enables under random sources
        tag = "R5";
        wr(0, 8'h85); wr(1, 8'h42); wr(3, 8'h02);
        for (int i = 0; i < 200; i++) step(13'($urandom), 0, 0, 0, i % 4, 0);

        // R10: long random mix
        tag = "R10";
        for (int i = 0; i < 4000; i++) begin
            int ad = int'($urandom % 4);
            bit w  = ($urandom % 16) == 0;
            step(13'($urandom) & 13'($urandom), ($urandom % 3) == 0,
                 ($urandom % 4) == 0, w, ad, 8'($urandom));
        end
        finish_run();
    end

endmodule